// File: doc/BRIEF.md
# DMA Address Protection Filter

This block sits on the address path of a graphics DMA master. It holds one protection register, written and read through a simple register port. Every address presented with a valid strobe is checked against that register. One cycle later exactly one of two outputs pulses: allow or deny.

Three regions are guarded by cutoff counts, and each count moves a protection floor down from the top of its region. The main region (0x20000000–0x27FFFFFF) and the extended region (0x28000000–0x2FFFFFFF) use 4-bit counts in 8 MiB steps. The auxiliary region (0x1F000000–0x1F3FFFFF) uses a 2-bit count in 1 MiB steps. A single lock bit closes the whole on-chip RAM (0x1FF80000–0x1FFFFFFF). A zero register leaves all memory open.

Register layout, where bit positions are behaviour:

| Bits | Meaning |
|------|---------|
| 3:0 | main cutoff |
| 7:4 | extended cutoff |
| 8 | on-chip RAM lock |
| 10:9 | auxiliary cutoff |
| 31:11 | read as zero |

Top module: `dma_guard`

## Requirements
- R1: After reset the register reads 0, allow_o and deny_o are low, and every address is allowed.
- R2: Register bits 31:11 ignore writes and always read as zero. Bits 10:0 read back as written.
- R3: For an address given with addr_valid_i high in cycle N, exactly one of allow_o and deny_o is high in cycle N+1. Both are low in any cycle that does not follow a valid address.
- R4: With main cutoff m (bits 3:0) non-zero, an address from 0x28000000 − m·0x800000 up to 0x27FFFFFF is denied. Lower main addresses are allowed.
- R5: With extended cutoff n (bits 7:4) non-zero, an address from 0x30000000 − n·0x800000 up to 0x2FFFFFFF is denied.
- R6: A zero cutoff protects nothing in its region. Main addresses 0x20000000–0x207FFFFF are allowed for every register value.
- R7: When the main cutoff is non-zero, extended addresses 0x28000000–0x287FFFFF are denied, whatever the extended cutoff is.
- R8: With bit 8 set, every address in 0x1FF80000–0x1FFFFFFF is denied. With bit 8 clear, all of it is allowed.
- R9: With auxiliary cutoff q (bits 10:9) non-zero, an address from 0x1F400000 − q·0x100000 up to 0x1F3FFFFF is denied.
- R10: Addresses outside the four regions are always allowed.
- R11: When main and extended cutoffs are both non-zero, an address is denied if any of the rules R4, R5 or R7 denies it.
- R12: A write in cycle N reads back in cycle N+1 and governs addresses presented from cycle N+1. An address presented in cycle N is judged with the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |
| addr_valid_i | input | 1 | DMA address valid |
| addr_i | input | 32 | DMA access address |
| allow_o | output | 1 | Access allowed, one cycle after valid |
| deny_o | output | 1 | Access denied, one cycle after valid |

## Verification
The verdict for an address driven in one cycle is due in the next cycle. Read data reflects a write one cycle after the write strobe. The bench drives inputs on the falling edge and checks at the following falling edge, so every check lands after exactly one rising edge. Its behavioural model updates its copy of the register only after computing the verdict for that cycle, which gives the old-value rule for a write and an address in the same cycle. Addresses are placed at each floor, one byte below it, at region edges, and outside every region.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned CFG_W  = 11;

  typedef struct packed {
    logic [1:0] aux_cut;
    logic       sram_lock;
    logic [3:0] ext_cut;
    logic [3:0] main_cut;
  } prot_cfg_t;

  localparam logic [AW-1:0] MAIN_BASE  = 32'h2000_0000;
  localparam logic [AW-1:0] MAIN_LIMIT = 32'h27FF_FFFF;
  localparam logic [AW-1:0] EXT_BASE   = 32'h2800_0000;
  localparam logic [AW-1:0] EXT_LIMIT  = 32'h2FFF_FFFF;
  localparam logic [AW-1:0] AUX_BASE   = 32'h1F00_0000;
  localparam logic [AW-1:0] AUX_LIMIT  = 32'h1F3F_FFFF;
  localparam logic [AW-1:0] SRAM_BASE  = 32'h1FF8_0000;
  localparam logic [AW-1:0] SRAM_LIMIT = 32'h1FFF_FFFF;
  localparam logic [AW-1:0] BIG_STEP   = 32'h0080_0000;
  localparam logic [AW-1:0] AUX_STEP   = 32'h0010_0000;
endpackage

// File: rtl/dma_guard_regs.sv
module dma_guard_regs
  import dma_guard_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output prot_cfg_t     cfg_o,
  output logic [DW-1:0] rdata_o
);
  prot_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= prot_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(DW-CFG_W){1'b0}}, cfg_q};

  a_r12_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[CFG_W-1:0] == $past(wdata_i[CFG_W-1:0]));
  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/dma_guard_window.sv
module dma_guard_window #(
  parameter int unsigned          AW    = 32,
  parameter int unsigned          CW    = 4,
  parameter logic [AW-1:0]        BASE  = '0,
  parameter logic [AW-1:0]        LIMIT = '1,
  parameter logic [AW-1:0]        STEP  = 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cut_i,
  output logic          in_o,
  output logic          hit_o
);
  localparam logic [AW:0] TOP = {1'b0, LIMIT} + 1'b1;

  logic [AW:0] floor_w;

  assign in_o    = (addr_i >= BASE) && (addr_i <= LIMIT);
  // floor moves down from region top by cut steps
  assign floor_w = TOP - ((AW+1)'(cut_i) * (AW+1)'(STEP));
  assign hit_o   = in_o && (cut_i != '0) && ({1'b0, addr_i} >= floor_w);
endmodule

// File: rtl/dma_guard_verdict.sv
module dma_guard_verdict
  import dma_guard_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          main_in_i,
  input  logic          ext_in_i,
  input  logic          aux_in_i,
  input  logic          sram_in_i,
  input  logic          main_hit_i,
  input  logic          ext_hit_i,
  input  logic          aux_hit_i,
  input  logic          sram_hit_i,
  input  logic          main_on_i,
  input  logic          sram_lock_i,
  output logic          allow_o,
  output logic          deny_o
);
  logic ext_floor_hit;
  logic block_w;
  logic outside_w;

  // main protection also closes the bottom step of the extended region
  assign ext_floor_hit = ext_in_i && main_on_i && (addr_i < (EXT_BASE + BIG_STEP));
  assign block_w   = main_hit_i | ext_hit_i | ext_floor_hit | aux_hit_i | sram_hit_i;
  assign outside_w = !(main_in_i | ext_in_i | aux_in_i | sram_in_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      allow_o <= valid_i & ~block_w;
      deny_o  <= valid_i &  block_w;
    end
  end

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && deny_o));
  a_r3_result_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (allow_o || deny_o));
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(allow_o || deny_o));
  a_r10_outside_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && outside_w) |=> allow_o);
  a_r6_main_floor_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && main_in_i && addr_i < (MAIN_BASE + BIG_STEP)) |=> allow_o);
  a_r8_sram_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sram_in_i && sram_lock_i) |=> deny_o);
endmodule

// File: rtl/dma_guard.sv
module dma_guard
  import dma_guard_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          addr_valid_i,
  input  logic [31:0]   addr_i,
  output logic          allow_o,
  output logic          deny_o
);
  prot_cfg_t cfg;
  logic main_in, ext_in, aux_in, sram_in;
  logic main_hit, ext_hit, aux_hit, sram_hit;

  dma_guard_regs #(.DW(32)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .cfg_o(cfg), .rdata_o(cfg_rdata_o)
  );

  dma_guard_window #(.AW(AW), .CW(4), .BASE(MAIN_BASE), .LIMIT(MAIN_LIMIT), .STEP(BIG_STEP))
    u_win_main (.addr_i(addr_i), .cut_i(cfg.main_cut), .in_o(main_in), .hit_o(main_hit));

  dma_guard_window #(.AW(AW), .CW(4), .BASE(EXT_BASE), .LIMIT(EXT_LIMIT), .STEP(BIG_STEP))
    u_win_ext (.addr_i(addr_i), .cut_i(cfg.ext_cut), .in_o(ext_in), .hit_o(ext_hit));

  dma_guard_window #(.AW(AW), .CW(2), .BASE(AUX_BASE), .LIMIT(AUX_LIMIT), .STEP(AUX_STEP))
    u_win_aux (.addr_i(addr_i), .cut_i(cfg.aux_cut), .in_o(aux_in), .hit_o(aux_hit));

  // whole-window lock: one step spans the region
  dma_guard_window #(.AW(AW), .CW(1), .BASE(SRAM_BASE), .LIMIT(SRAM_LIMIT),
                     .STEP(SRAM_LIMIT - SRAM_BASE + 1))
    u_win_sram (.addr_i(addr_i), .cut_i(cfg.sram_lock), .in_o(sram_in), .hit_o(sram_hit));

  dma_guard_verdict u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(addr_valid_i), .addr_i(addr_i),
    .main_in_i(main_in), .ext_in_i(ext_in), .aux_in_i(aux_in), .sram_in_i(sram_in),
    .main_hit_i(main_hit), .ext_hit_i(ext_hit), .aux_hit_i(aux_hit), .sram_hit_i(sram_hit),
    .main_on_i(cfg.main_cut != 4'd0), .sram_lock_i(cfg.sram_lock),
    .allow_o(allow_o), .deny_o(deny_o)
  );
endmodule

// File: tb/dma_guard_bench.sv
module dma_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        valid = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] rdata;
  logic        allow, deny;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  longint model_reg = 0;

  always #10 clk = ~clk;

  dma_guard u_dma_guard (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .addr_valid_i(valid), .addr_i(addr),
    .allow_o(allow), .deny_o(deny)
  );

  function automatic bit blocked(longint r, longint a);
    longint m = r & 15;
    longint n = (r >> 4) & 15;
    longint q = (r >> 9) & 3;
    bit lock  = bit'((r >> 8) & 1);
    if (a >= 64'h2000_0000 && a < 64'h2800_0000)
      return m != 0 && a >= 64'h2800_0000 - m * 64'h80_0000;
    if (a >= 64'h2800_0000 && a < 64'h3000_0000)
      return (n != 0 && a >= 64'h3000_0000 - n * 64'h80_0000) ||
             (m != 0 && a < 64'h2880_0000);
    if (a >= 64'h1F00_0000 && a < 64'h1F40_0000)
      return q != 0 && a >= 64'h1F40_0000 - q * 64'h10_0000;
    if (a >= 64'h1FF8_0000 && a < 64'h2000_0000)
      return lock;
    return 0;
  endfunction

  // drive at falling edge, check at next falling edge
  task automatic cyc(input string tag, input bit w, input logic [31:0] wd,
                     input bit v, input logic [31:0] a);
    bit exp_a, exp_d;
    longint exp_r;
    we = w; wdata = wd; valid = v; addr = a;
    exp_d = v && blocked(model_reg, longint'(a));
    exp_a = v && !exp_d;
    if (w) model_reg = longint'(wd) & 64'h7FF;
    exp_r = model_reg;
    @(negedge clk);
    tests++;
    if (allow !== exp_a || deny !== exp_d) begin
      fails++;
      $display("FAIL %s addr=%h allow/deny=%b%b expected %b%b", tag, a, allow, deny, exp_a, exp_d);
    end
    tests++;
    if (longint'(rdata) != exp_r) begin
      fails++;
      $display("FAIL %s rdata=%h expected %h", tag, rdata, exp_r[31:0]);
    end
  endtask

  task automatic probe(input string tag, input logic [31:0] a);
    cyc(tag, 1'b0, '0, 1'b1, a);
  endtask

  task automatic setreg(input logic [31:0] v);
    cyc("R12", 1'b1, v, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (rdata !== 32'd0 || allow !== 1'b0 || deny !== 1'b0) begin
      fails++;
      $display("FAIL R1 rdata=%h allow=%b deny=%b expected 0 0 0", rdata, allow, deny);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1", 0, '0, 0, '0);
    probe("R1", 32'h27FF_FFFC);
    probe("R1", 32'h1FF8_0000);
    probe("R1", 32'h2FFF_0000);
    // reserved bits
    setreg(32'hFFFF_FFFF);
    cyc("R2", 0, '0, 0, '0);
    setreg(32'hA5A5_F800);
    cyc("R2", 0, '0, 0, '0);
    // main cutoff
    for (int m = 0; m < 16; m++) begin
      setreg(32'(m));
      probe("R4", 32'h2800_0000 - 32'(m) * 32'h80_0000);
      probe("R4", 32'h27FF_FFFF - 32'(m) * 32'h80_0000);
      probe("R6", 32'h207F_FFFF);
      probe("R6", 32'h2000_0000);
      probe("R7", 32'h2800_0000);
      probe("R7", 32'h287F_FFFF);
      probe("R7", 32'h2880_0000);
    end
    // extended cutoff alone
    for (int n = 0; n < 16; n++) begin
      setreg(32'(n) << 4);
      probe("R5", 32'h3000_0000 - 32'(n) * 32'h80_0000);
      probe("R5", 32'h2FFF_FFFF - 32'(n) * 32'h80_0000);
      probe("R5", 32'h2FFF_FFFF);
      probe("R6", 32'h27FF_FFFF);
    end
    // union of main and extended
    setreg(32'h0000_0031);
    probe("R11", 32'h2780_0000);
    probe("R11", 32'h2700_0000);
    probe("R11", 32'h2800_0004);
    probe("R11", 32'h2C00_0000);
    probe("R11", 32'h2E80_0000);
    probe("R11", 32'h2E7F_FFFF);
    // on-chip RAM lock
    setreg(32'h0000_0100);
    probe("R8", 32'h1FF8_0000);
    probe("R8", 32'h1FFF_FFFF);
    probe("R8", 32'h1FF7_FFFF);
    probe("R10", 32'h2000_0000);
    setreg(32'h0000_0000);
    probe("R8", 32'h1FFC_0000);
    // auxiliary cutoff
    for (int q = 0; q < 4; q++) begin
      setreg(32'(q) << 9);
      probe("R9", 32'h1F40_0000 - 32'(q) * 32'h10_0000);
      probe("R9", 32'h1F3F_FFFF - 32'(q) * 32'h10_0000);
      probe("R9", 32'h1F3F_FFFF);
      probe("R10", 32'h1F40_0000);
    end
    // everything closed, outside addresses stay open
    setreg(32'h0000_07FF);
    probe("R10", 32'h0000_0000);
    probe("R10", 32'h1EFF_FFFF);
    probe("R10", 32'h1FF7_FFFF);
    probe("R10", 32'h3000_0000);
    probe("R10", 32'hFFFF_FFFF);
    probe("R6", 32'h2000_1000);
    // write and address in the same cycle
    setreg(32'h0000_0000);
    cyc("R12", 1'b1, 32'h0000_0100, 1'b1, 32'h1FF9_0000);
    probe("R12", 32'h1FF9_0000);
    cyc("R12", 1'b1, 32'h0000_0000, 1'b1, 32'h1FF9_0000);
    probe("R12", 32'h1FF9_0000);
    // back-to-back valid then idle
    setreg(32'h0000_0001);
    probe("R3", 32'h27F0_0000);
    probe("R3", 32'h2000_0000);
    cyc("R3", 0, '0, 0, 32'h27F0_0000);
    // reset mid-run clears the register
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reg = 0;
    probe("R1", 32'h27F0_0000);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule